// File: doc/BRIEF.md
# Power-Up Delay Timer with Low-Power Oscillator Gating

This block times the power-up delay of a chip from a slow, always-available low-power oscillator. It also decides whether that oscillator stays enabled once the delay is over. From power-on reset it counts a parameterised number of low-power clock cycles. Until that count completes, it holds the core in reset and forces the oscillator enable on. The expired flag crosses into the system clock domain through a chain of synchroniser flops. That synchronised flag drives the core's reset release.

After expiry, the oscillator enable is worked out again on every cycle from three keep-alive conditions:
- the fail-safe clock monitor is enabled and the chip is not asleep;
- the watchdog is enabled;
- the current clock-group code selects the low-power oscillator as system clock.

When none of these holds, the enable drops. When one of them returns, the enable comes back on without a reset. While the monitor is enabled and the chip is awake, the watchdog enable has no effect on the oscillator.

The analog oscillator is modelled as a free-running clock input. Watchdog counting and clock switching sit outside this block.

Top module: `pwrup_osc_gate`

## Requirements
- R1: While `por_n` is low, and after its release until the delay has expired, `lposc_en` is 1 whatever the other inputs are.
- R2: The delay expires on exactly the `DLY_CYCLES`-th rising `lp_clk` edge after `por_n` rises (default 64). It stays expired until the next power-on reset.
- R3: `core_rst_hold` is 1 from power-on reset until `tmr_done` rises, and 0 afterwards.
- R4: After expiry, `lposc_en` is 1 whenever `mon_en_cfg` is 1 and `sleep_req` is 0, whatever `wdt_en_cfg` is.
- R5: After expiry, `lposc_en` is 1 whenever `wdt_en_cfg` is 1, asleep or not.
- R6: After expiry, `lposc_en` is 1 whenever `cur_grp` equals the low-power group code 3'b101, asleep or not.
- R7: After expiry, `lposc_en` is 0 when none of the R4, R5 and R6 conditions holds. This includes the case of monitor enabled while `sleep_req` is 1.
- R8: `tmr_done` is 0 during reset. It rises on the `SYNC_STAGES`-th (default 2) rising `sys_clk` edge after the low-power-domain expiry, never earlier.
- R9: `lposc_en` follows its inputs combinationally after expiry. Moving `cur_grp` back to 3'b101 turns it on again without any reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| lp_clk | input | 1 | Free-running low-power oscillator clock |
| sys_clk | input | 1 | System clock for the synchronised flag |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sleep_req | input | 1 | Chip is in sleep |
| mon_en_cfg | input | 1 | Fail-safe clock monitor enable configuration |
| wdt_en_cfg | input | 1 | Watchdog enable configuration |
| cur_grp | input | 3 | Current clock-group code |
| tmr_done | output | 1 | Delay expired, synchronised to `sys_clk` |
| core_rst_hold | output | 1 | Holds the core in reset while 1 |
| lposc_en | output | 1 | Low-power oscillator enable |

## Verification
The bench counts `lp_clk` edges from reset release and samples just before and just after the terminal edge. A counter that is off by one would drop the enable one edge early or late. A synchroniser that is too short, or bypassed, would show `tmr_done` before the second system edge. A vector table covers each keep-alive condition alone and in combination, including monitor-enabled-while-asleep. A design that ignores sleep, or that lets the watchdog bit mask the monitor, would miscompare there. Directed tests cover recovery of the enable by group code without reset, and a second power-on reset issued after expiry. That second reset must force the enable on and clear the synchronised flag at once.

// File: rtl/pwg_pkg.sv
package pwg_pkg;

   localparam int unsigned GRP_W = 3;

   typedef logic [GRP_W-1:0] grp_code_t;

   // clock-group code that selects the low-power oscillator as system clock
   localparam grp_code_t GRP_LOWPWR = 3'b101;

   typedef struct packed {
      logic      sleep;
      logic      mon_en;
      logic      wdt_en;
      grp_code_t grp;
   } keep_in_t;

endpackage

// File: rtl/pwg_delay_cnt.sv
module pwg_delay_cnt #(
   parameter int unsigned DLY_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   output logic done
);
   localparam int unsigned CNT_W = (DLY_CYCLES > 2) ? $clog2(DLY_CYCLES) : 1;
   localparam logic [CNT_W-1:0] TERM = CNT_W'(DLY_CYCLES - 1);

   if (DLY_CYCLES < 2) begin : g_bad_len
      $error("pwg_delay_cnt: DLY_CYCLES must be at least 2");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (!done) begin
         if (cnt == TERM) done <= 1'b1;
         else             cnt  <= cnt + 1'b1;
      end
   end

   // R2: expiry is sticky until the next power-on reset
   a_r2_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

   // R2: the count freezes once expired
   a_r2_cnt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> $stable(cnt));

   // R2: the count never passes its terminal value
   a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= TERM);

endmodule

// File: rtl/pwg_sync.sv
module pwg_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pwg_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] stg;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= 1'b0;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= 1'b0;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];

   // R8: the output never rises unless the input was already high
   a_r8_no_early_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(q) |-> $past(d));

endmodule

// File: rtl/pwg_osc_gate.sv
module pwg_osc_gate
   import pwg_pkg::*;
#(
   parameter grp_code_t LP_CODE = GRP_LOWPWR
) (
   input  logic     expired,
   input  keep_in_t cfg,
   output logic     osc_en
);
   logic keep_mon, keep_wdt, keep_grp;

   always_comb begin
      keep_mon = cfg.mon_en & ~cfg.sleep;
      keep_wdt = cfg.wdt_en;
      keep_grp = (cfg.grp == LP_CODE);
      osc_en   = ~expired | keep_mon | keep_wdt | keep_grp;
   end

endmodule

// File: rtl/pwrup_osc_gate.sv
module pwrup_osc_gate
   import pwg_pkg::*;
#(
   parameter int unsigned DLY_CYCLES  = 64,
   parameter int unsigned SYNC_STAGES = 2,
   parameter grp_code_t   LP_CODE     = GRP_LOWPWR
) (
   input  logic       lp_clk,
   input  logic       sys_clk,
   input  logic       por_n,
   input  logic       sleep_req,
   input  logic       mon_en_cfg,
   input  logic       wdt_en_cfg,
   input  logic [2:0] cur_grp,
   output logic       tmr_done,
   output logic       core_rst_hold,
   output logic       lposc_en
);
   logic     lp_expired;
   keep_in_t keep_cfg;

   pwg_delay_cnt #(.DLY_CYCLES(DLY_CYCLES)) u_cnt (
      .clk   (lp_clk),
      .rst_n (por_n),
      .done  (lp_expired)
   );

   pwg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (sys_clk),
      .rst_n (por_n),
      .d     (lp_expired),
      .q     (tmr_done)
   );

   assign keep_cfg = '{sleep: sleep_req, mon_en: mon_en_cfg,
                       wdt_en: wdt_en_cfg, grp: cur_grp};

   pwg_osc_gate #(.LP_CODE(LP_CODE)) u_gate (
      .expired (lp_expired),
      .cfg     (keep_cfg),
      .osc_en  (lposc_en)
   );

   assign core_rst_hold = ~tmr_done;

   // R1: forced on until the delay expires
   a_r1_forced_on: assert property (@(posedge lp_clk) disable iff (!por_n)
      !lp_expired |-> lposc_en);

   // R4: monitor while awake keeps it on
   a_r4_mon_keeps: assert property (@(posedge lp_clk) disable iff (!por_n)
      (mon_en_cfg && !sleep_req) |-> lposc_en);

   // R5: watchdog keeps it on
   a_r5_wdt_keeps: assert property (@(posedge lp_clk) disable iff (!por_n)
      wdt_en_cfg |-> lposc_en);

   // R6: low-power group selected keeps it on
   a_r6_grp_keeps: assert property (@(posedge lp_clk) disable iff (!por_n)
      (cur_grp == LP_CODE) |-> lposc_en);

   // R7: off once expired with no keep-alive condition
   a_r7_idle_off: assert property (@(posedge lp_clk) disable iff (!por_n)
      (lp_expired && !wdt_en_cfg && (cur_grp != LP_CODE)
       && !(mon_en_cfg && !sleep_req)) |-> !lposc_en);

   // R3: the core is released only after the low-power domain expired
   a_r3_release_after_expiry: assert property (@(posedge sys_clk) disable iff (!por_n)
      !core_rst_hold |-> lp_expired);

endmodule

// File: tb/pwrup_osc_gate_bench.sv
`timescale 1ns/100ps
module pwrup_osc_gate_bench;
   localparam int unsigned DLY = 64;
   localparam int NVEC = 11;

   // vector: {sleep, mon, wdt, grp[2:0], expected lposc_en}
   localparam logic [6:0] VEC [NVEC] = '{
      7'b0_0_0_000_0, 7'b0_1_0_000_1, 7'b1_1_0_000_0, 7'b0_1_1_010_1,
      7'b0_0_1_000_1, 7'b1_0_1_011_1, 7'b0_0_0_101_1, 7'b1_0_0_101_1,
      7'b0_0_0_100_0, 7'b0_1_0_111_1, 7'b1_0_0_001_0 };

   logic lp_clk = 1'b0, sys_clk = 1'b0, por_n = 1'b0;
   logic sleep_req = 1'b0, mon_en_cfg = 1'b0, wdt_en_cfg = 1'b0;
   logic [2:0] cur_grp = 3'b000;
   logic tmr_done, core_rst_hold, lposc_en;

   int n_chk = 0, n_bad = 0;
   bit finished = 1'b0;

   always #2.5 sys_clk = ~sys_clk;
   initial begin
      #1;
      forever #20 lp_clk = ~lp_clk;
   end

   pwrup_osc_gate #(.DLY_CYCLES(DLY)) u_pwrup_osc_gate (
      .lp_clk, .sys_clk, .por_n, .sleep_req, .mon_en_cfg, .wdt_en_cfg,
      .cur_grp, .tmr_done, .core_rst_hold, .lposc_en
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   function automatic string tag_of(input logic [6:0] v);
      if (!v[0])              return "R7";
      if (v[4])               return "R5";
      if (v[3:1] == 3'b101)   return "R6";
      return "R4";
   endfunction

   initial begin
      #50;
      check("R1 reset enable", lposc_en, 1'b1);
      check("R3 reset hold", core_rst_hold, 1'b1);
      check("R8 reset flag", tmr_done, 1'b0);

      @(negedge lp_clk) por_n = 1'b1;
      repeat (DLY - 1) @(posedge lp_clk);
      #5;
      check("R2 not yet expired", lposc_en, 1'b1);
      check("R3 still held", core_rst_hold, 1'b1);
      @(posedge lp_clk);
      #5;
      check("R2 expired on terminal edge", lposc_en, 1'b0);
      check("R8 flag lags one stage", tmr_done, 1'b0);
      #4;
      check("R8 flag after two stages", tmr_done, 1'b1);
      check("R3 released", core_rst_hold, 1'b0);

      for (int i = 0; i < NVEC; i++) begin
         @(negedge sys_clk);
         {sleep_req, mon_en_cfg, wdt_en_cfg, cur_grp} = VEC[i][6:1];
         #1;
         check(tag_of(VEC[i]), lposc_en, VEC[i][0]);
      end

      // R9: recovery by group code without reset
      @(negedge sys_clk);
      {sleep_req, mon_en_cfg, wdt_en_cfg, cur_grp} = 6'b0_0_0_000;
      #1 check("R9 off", lposc_en, 1'b0);
      cur_grp = 3'b101;
      #1 check("R9 back on", lposc_en, 1'b1);
      cur_grp = 3'b000;
      #1 check("R9 off again", lposc_en, 1'b0);

      // second power-on reset after expiry
      @(negedge sys_clk) por_n = 1'b0;
      #1;
      check("R1 re-reset enable", lposc_en, 1'b1);
      check("R8 re-reset flag", tmr_done, 1'b0);
      check("R3 re-reset hold", core_rst_hold, 1'b1);

      // forced on before expiry even asleep with monitor enabled
      @(negedge lp_clk) por_n = 1'b1;
      sleep_req = 1'b1; mon_en_cfg = 1'b1;
      repeat (10) @(posedge lp_clk);
      #5 check("R1 forced before expiry", lposc_en, 1'b1);
      repeat (DLY - 10) @(posedge lp_clk);
      #5 check("R7 asleep monitor off", lposc_en, 1'b0);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #200000;
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule